// File: doc/BRIEF.md
# Translation Cache with One-Hot Permission Test

This block is a small direct-mapped cache that sits in front of a page walker and holds recent linear-to-physical page translations. Each of its entries keeps a linear page tag, a physical frame number, a global flag and a four-bit access-rights mask. A lookup either hits, meaning the tag matches and the rights allow the access, and returns the physical address at once, or it asks the walker for a fresh walk. A rights failure on a matching tag is never a fault here. It only forces a walk, so the walker can make the decision and update the accessed and dirty state in memory.

The walker writes its results back through a fill port. The block does not cache write rights unless the walk was caused by a write. The first write to a page that was filled by a read therefore always goes back to the walker, which is where the dirty flag gets set. The block supports four kinds of invalidation, all completed in a single clock:
- a whole-cache wipe whenever any paging mode flag changes;
- a wipe of the non-global entries whenever the root table pointer is loaded;
- removal of one entry by page;
- removal of one entry after a translation fault.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is empty, so any lookup reports a walk request and no hit.
- R2: After a fill, a lookup that the cached rights allow and whose page bits 31..12 match reports a hit. The physical address it returns is the filled frame in bits 31..12 and the lookup's own bits 11..0.
- R3: The rights mask uses bit 0 for a supervisor read, bit 1 for a user read, bit 2 for a supervisor write and bit 3 for a user write. An access is allowed when bit {write,user} is set. A fill of a user page sets both read bits, and a fill of a supervisor page sets only bit 0.
- R4: The write bits are set only when the fill was caused by a write. Such a fill sets both write bits for a user page and only bit 2 for a supervisor page.
- R5: A lookup whose tag matches but whose rights are denied reports a walk request, not a hit.
- R6: A lookup that reaches a valid entry with a different tag reports a walk request.
- R7: A root-pointer load pulse empties every entry whose global flag is clear and keeps global entries. It does this on every pulse, with no value compared.
- R8: Any change of the six mode flags empties every entry, global ones included. Flags that stay the same empty nothing.
- R9: A page invalidate empties only the entry selected by bits 16..12 of the given page.
- R10: A fault report empties only the entry selected by bits 16..12 of the faulting page.
- R11: When a fill and a clearing operation hit the same entry in one cycle, the clear wins and the entry ends up empty.
- R12: While a lookup is presented, exactly one of hit and walk request is high. With no lookup, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_vaddr | input | 32 | Linear address of the lookup |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup made at user privilege |
| lk_hit | output | 1 | Tag matches and rights allow the access |
| lk_walk | output | 1 | Walk required (miss or rights denied) |
| lk_paddr | output | 32 | Physical address, meaningful when lk_hit is high |
| fill_valid | input | 1 | Walker result to store |
| fill_vpn | input | 20 | Linear page number (address bits 31..12) of the fill |
| fill_frame | input | 20 | Physical frame number for the fill |
| fill_user | input | 1 | Filled page is user accessible |
| fill_write | input | 1 | Walk was caused by a write |
| fill_global | input | 1 | Filled page is global |
| root_load | input | 1 | Root table pointer was written |
| mode_flags | input | 6 | Current paging mode flags; any change flushes all |
| inv_valid | input | 1 | Invalidate a single page |
| inv_idx | input | 5 | Bits 16..12 of the page to invalidate |
| fault_valid | input | 1 | Translation fault reported |
| fault_idx | input | 5 | Bits 16..12 of the faulting page |

## Verification
A wrong valid, tag or rights bit shows up combinationally on lk_hit and lk_walk at the first lookup of that index after the faulty clock edge. A wrong stored frame shows on lk_paddr in that same cycle. The sweeps therefore fill each of the 32 indices under all four fill kinds and probe every access kind right after the fill. This exposes a bad encoding of the rights mask within one cycle. Flush masking errors, such as a global entry lost or a non-global entry kept, show on the lookup made in the cycle after the pulse. Each flush is followed by a probe of all indices.

// File: rtl/xlat_pkg.sv
// Shared constants and helpers for the translation cache.
// Assumes 4 KiB pages and a four-bit rights mask indexed by {write,user}.
package xlat_pkg;
    localparam int PAGE_BITS = 12;
    localparam int PERM_W    = 4;
    localparam int MODE_W    = 6;

    // Rights mask bit positions
    localparam int PB_RD_SUP = 0;
    localparam int PB_RD_USR = 1;
    localparam int PB_WR_SUP = 2;
    localparam int PB_WR_USR = 3;

    typedef logic [PERM_W-1:0] perm_t;

    // Selects the rights bit an access must find set
    function automatic logic [1:0] perm_sel(input logic is_write, input logic is_user);
        return {is_write, is_user};
    endfunction
endpackage

// File: rtl/xlat_perm.sv
// Rights encoder and checker.
// Builds the rights mask stored on a fill and tests a cached mask against
// an access. Purely combinational; assumes the walker already merged the
// directory and table level rights into fill_user.
module xlat_perm
    import xlat_pkg::*;
(
    input  logic  fill_user,
    input  logic  fill_write,
    output perm_t fill_perm,
    input  perm_t chk_perm,
    input  logic  chk_write,
    input  logic  chk_user,
    output logic  chk_ok
);
    // Encode: reads always for supervisor, user rights only for user pages,
    // write rights only if the fill came from a write.
    always_comb begin
        fill_perm            = '0;
        fill_perm[PB_RD_SUP] = 1'b1;
        fill_perm[PB_RD_USR] = fill_user;
        fill_perm[PB_WR_SUP] = fill_write;
        fill_perm[PB_WR_USR] = fill_write & fill_user;
    end

    // One-hot test of the selected rights bit
    assign chk_ok = chk_perm[perm_sel(chk_write, chk_user)];
endmodule

// File: rtl/xlat_flush_ctl.sv
// Flush and invalidate control.
// Tracks the mode flags to detect changes and decodes single-entry clears.
// Assumes the clear requests are one-cycle pulses.
module xlat_flush_ctl
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  mode_flags,
    input  logic               root_load,
    input  logic               inv_valid,
    input  logic [IDX_W-1:0]   inv_idx,
    input  logic               fault_valid,
    input  logic [IDX_W-1:0]   fault_idx,
    output logic               flush_all,
    output logic               flush_nonglobal,
    output logic [ENTRIES-1:0] clr_entry
);
    logic [MODE_W-1:0] mode_q;

    // Remember last cycle's mode flags
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_flags;
    end

    assign flush_all       = (mode_flags != mode_q);
    assign flush_nonglobal = root_load;

    // Per-entry clear decode from page invalidate and fault report
    for (genvar g = 0; g < ENTRIES; g++) begin : g_clr
        assign clr_entry[g] = (inv_valid   && (inv_idx   == IDX_W'(g))) ||
                              (fault_valid && (fault_idx == IDX_W'(g)));
    end
endmodule

// File: rtl/xlat_store.sv
// Entry storage.
// Holds valid, global, tag, frame and rights per entry, with one write port
// and one read port. Clears are applied after the fill, so a clear in the
// same cycle wins.
module xlat_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES  = 32,
    parameter int TAG_W    = 15,
    parameter int FRAME_W  = 20,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [FRAME_W-1:0] wr_frame,
    input  perm_t              wr_perm,
    input  logic               wr_global,
    input  logic               flush_all,
    input  logic               flush_nonglobal,
    input  logic [ENTRIES-1:0] clr_entry,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [FRAME_W-1:0] rd_frame,
    output perm_t              rd_perm
);
    logic [ENTRIES-1:0] valid_q, glob_q;
    logic [TAG_W-1:0]   tag_q   [ENTRIES];
    logic [FRAME_W-1:0] frame_q [ENTRIES];
    perm_t              perm_q  [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic we, glob_n, keep;

        assign we     = wr_en && (wr_idx == IDX_W'(g));
        assign glob_n = we ? wr_global : glob_q[g];
        assign keep   = !(flush_all || (flush_nonglobal && !glob_n) || clr_entry[g]);

        // Valid bit: set by fill, then masked by any clear
        always_ff @(posedge clk) begin
            if (!rst_n) valid_q[g] <= 1'b0;
            else        valid_q[g] <= (we || valid_q[g]) && keep;
        end

        // Entry payload written on fill
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                glob_q[g]  <= 1'b0;
                tag_q[g]   <= '0;
                frame_q[g] <= '0;
                perm_q[g]  <= '0;
            end else if (we) begin
                glob_q[g]  <= wr_global;
                tag_q[g]   <= wr_tag;
                frame_q[g] <= wr_frame;
                perm_q[g]  <= wr_perm;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_frame = frame_q[rd_idx];
    assign rd_perm  = perm_q[rd_idx];
endmodule

// File: rtl/xlat_cache.sv
// Direct-mapped translation cache, top level.
// Lookup is combinational from stored state. A hit needs a valid entry,
// a matching tag and an allowed access; anything else asks for a walk.
// Assumes the walker fills after every walk it was asked for.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int ENTRIES = 32,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int VPN_W   = VA_W - PAGE_BITS,
    localparam int FRAME_W = PA_W - PAGE_BITS,
    localparam int TAG_W   = VPN_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic               lk_write,
    input  logic               lk_user,
    output logic               lk_hit,
    output logic               lk_walk,
    output logic [PA_W-1:0]    lk_paddr,
    input  logic               fill_valid,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               fill_user,
    input  logic               fill_write,
    input  logic               fill_global,
    input  logic               root_load,
    input  logic [MODE_W-1:0]  mode_flags,
    input  logic               inv_valid,
    input  logic [IDX_W-1:0]   inv_idx,
    input  logic               fault_valid,
    input  logic [IDX_W-1:0]   fault_idx
);
    logic               flush_all, flush_ng;
    logic [ENTRIES-1:0] clr_entry;
    perm_t              fill_perm, rd_perm;
    logic               rd_valid, perm_ok;
    logic [TAG_W-1:0]   rd_tag;
    logic [FRAME_W-1:0] rd_frame;
    logic [IDX_W-1:0]   lk_idx;
    logic [TAG_W-1:0]   lk_tag;

    assign lk_idx = lk_vaddr[PAGE_BITS +: IDX_W];
    assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];

    xlat_flush_ctl #(.ENTRIES(ENTRIES)) u_flush (
        .clk(clk), .rst_n(rst_n), .mode_flags(mode_flags), .root_load(root_load),
        .inv_valid(inv_valid), .inv_idx(inv_idx),
        .fault_valid(fault_valid), .fault_idx(fault_idx),
        .flush_all(flush_all), .flush_nonglobal(flush_ng), .clr_entry(clr_entry)
    );

    xlat_perm u_perm (
        .fill_user(fill_user), .fill_write(fill_write), .fill_perm(fill_perm),
        .chk_perm(rd_perm), .chk_write(lk_write), .chk_user(lk_user), .chk_ok(perm_ok)
    );

    xlat_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fill_valid), .wr_idx(fill_vpn[IDX_W-1:0]),
        .wr_tag(fill_vpn[VPN_W-1 -: TAG_W]), .wr_frame(fill_frame),
        .wr_perm(fill_perm), .wr_global(fill_global),
        .flush_all(flush_all), .flush_nonglobal(flush_ng), .clr_entry(clr_entry),
        .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .rd_frame(rd_frame), .rd_perm(rd_perm)
    );

    // Hit decision and walk request
    always_comb begin
        lk_hit   = lk_valid && rd_valid && (rd_tag == lk_tag) && perm_ok;
        lk_walk  = lk_valid && !lk_hit;
        lk_paddr = {rd_frame, lk_vaddr[PAGE_BITS-1:0]};
    end
endmodule

// File: rtl/xlat_cache_chk.sv
// Property checker for the translation cache, bound to the top.
// Keeps its own copy of last cycle's mode flags to spot changes.
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int ENTRIES = 32,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int VPN_W   = VA_W - PAGE_BITS,
    localparam int FRAME_W = PA_W - PAGE_BITS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               lk_write,
    input logic               lk_user,
    input logic               lk_hit,
    input logic               lk_walk,
    input logic [PA_W-1:0]    lk_paddr,
    input logic               fill_valid,
    input logic [VPN_W-1:0]   fill_vpn,
    input logic [FRAME_W-1:0] fill_frame,
    input logic               fill_user,
    input logic               fill_write,
    input logic               root_load,
    input logic [MODE_W-1:0]  mode_flags,
    input logic               inv_valid,
    input logic [IDX_W-1:0]   inv_idx,
    input logic               fault_valid,
    input logic [IDX_W-1:0]   fault_idx
);
    logic [MODE_W-1:0] mflags_q;
    logic              quiet;

    // Observed mode flags one cycle back
    always_ff @(posedge clk) begin
        if (!rst_n) mflags_q <= '0;
        else        mflags_q <= mode_flags;
    end

    assign quiet = !root_load && !inv_valid && !fault_valid && (mode_flags == mflags_q);

    AST_HIT_WALK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot({lk_hit, lk_walk})); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_walk)); // R12
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit); // R1
    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_valid && quiet) && lk_valid && !lk_write &&
         !(lk_user && !$past(fill_user)) && (lk_vaddr[VA_W-1:PAGE_BITS] == $past(fill_vpn)))
        |-> (lk_hit && (lk_paddr == {$past(fill_frame), lk_vaddr[PAGE_BITS-1:0]}))); // R2
    AST_READFILL_WRITE_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_valid && !fill_write) && lk_valid && lk_write &&
         (lk_vaddr[VA_W-1:PAGE_BITS] == $past(fill_vpn)))
        |-> lk_walk); // R5
    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_flags != mflags_q)) |-> !lk_hit); // R8
    AST_PAGE_INV: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(inv_valid) &&
         (lk_vaddr[PAGE_BITS +: IDX_W] == $past(inv_idx))) |-> !lk_hit); // R9
    AST_FAULT_INV: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fault_valid) &&
         (lk_vaddr[PAGE_BITS +: IDX_W] == $past(fault_idx))) |-> !lk_hit); // R10
endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit), .lk_walk(lk_walk),
    .lk_paddr(lk_paddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_frame(fill_frame), .fill_user(fill_user), .fill_write(fill_write),
    .root_load(root_load), .mode_flags(mode_flags), .inv_valid(inv_valid),
    .inv_idx(inv_idx), .fault_valid(fault_valid), .fault_idx(fault_idx)
);

// File: tb/xlat_cache_tb.sv
// Self-checking bench: sweeps all indices under every fill kind and flush.
module xlat_cache_tb;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0, lk_user = 0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_walk;
    logic [31:0] lk_paddr;
    logic        fill_valid = 0, fill_user = 0, fill_write = 0, fill_global = 0;
    logic [19:0] fill_vpn = '0, fill_frame = '0;
    logic        root_load = 0, inv_valid = 0, fault_valid = 0;
    logic [5:0]  mode_flags = '0;
    logic [4:0]  inv_idx = '0, fault_idx = '0;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xlat_cache u_dut (.*);

    function automatic logic [14:0] tag_of(int i, int k);
        return 15'h1234 ^ 15'(i * 37 + k);
    endfunction
    function automatic logic [19:0] frame_of(int i, int k);
        return 20'hA0000 ^ 20'(i * 131 + k * 7);
    endfunction
    // Expected permission from the rights rules (R3, R4)
    function automatic bit allowed(bit fu, bit fw, bit w, bit u);
        if (u && !fu) return 0;
        if (w && !fw) return 0;
        return 1;
    endfunction

    task automatic fill(int i, int k, bit u, bit w, bit g);
        fill_valid = 1; fill_vpn = {tag_of(i, k), 5'(i)}; fill_frame = frame_of(i, k);
        fill_user = u; fill_write = w; fill_global = g;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic look(string req, logic [14:0] tg, int i, bit w, bit u,
                        bit exp_hit, logic [19:0] exp_frame);
        logic [11:0] off;
        off = 12'(i * 97 + 5);
        lk_valid = 1; lk_vaddr = {tg, 5'(i), off}; lk_write = w; lk_user = u;
        #1;
        checks++;
        if (lk_hit !== exp_hit || lk_walk !== !exp_hit ||
            (exp_hit && lk_paddr !== {exp_frame, off})) begin
            fails++;
            $display("FAIL %s idx=%0d w=%0b u=%0b: hit=%0b walk=%0b paddr=%h, expected hit=%0b paddr=%h",
                     req, i, w, u, lk_hit, lk_walk, lk_paddr, exp_hit, {exp_frame, off});
        end
        @(negedge clk);
        lk_valid = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: empty after reset; R12: idle means neither output
        #1;
        checks++;
        if (lk_hit !== 0 || lk_walk !== 0) begin
            fails++;
            $display("FAIL R12 idle: hit=%0b walk=%0b, expected 0 0", lk_hit, lk_walk);
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) look("R1", tag_of(i, 0), i, 0, 0, 0, '0);

        // R2 R3 R4 R5 R6: each fill kind at every index, all four access kinds
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < N; i++) begin
                bit fu, fw;
                fu = k[0]; fw = k[1];
                fill(i, k, fu, fw, 0);
                for (int a = 0; a < 4; a++) begin
                    bit ex;
                    ex = allowed(fu, fw, a[1], a[0]);
                    look(ex ? "R2/R3/R4" : "R5", tag_of(i, k), i, a[1], a[0], ex, frame_of(i, k));
                end
                look("R6", tag_of(i, k) ^ 15'h1, i, 0, 0, 0, '0);
            end
        end

        // R7: root load keeps only global entries (odd indices global)
        for (int i = 0; i < N; i++) fill(i, 5, 1, 1, i[0]);
        root_load = 1; @(negedge clk); root_load = 0;
        for (int i = 0; i < N; i++) look("R7", tag_of(i, 5), i, 0, 0, i[0], frame_of(i, 5));
        root_load = 1; @(negedge clk); root_load = 0;
        for (int i = 1; i < N; i += 2) look("R7", tag_of(i, 5), i, 0, 1, 1, frame_of(i, 5));

        // R8: mode change flushes globals too; unchanged flags flush nothing
        for (int i = 0; i < N; i++) fill(i, 6, 1, 0, 1);
        repeat (2) @(negedge clk);
        for (int i = 0; i < N; i += 3) look("R8", tag_of(i, 6), i, 0, 0, 1, frame_of(i, 6));
        mode_flags = 6'b000100; @(negedge clk);
        for (int i = 0; i < N; i++) look("R8", tag_of(i, 6), i, 0, 0, 0, '0);
        for (int i = 0; i < N; i++) fill(i, 7, 0, 1, 1);
        mode_flags = 6'b100100; @(negedge clk);
        for (int i = 0; i < N; i++) look("R8", tag_of(i, 7), i, 1, 0, 0, '0);

        // R9: page invalidate clears only its index
        for (int i = 0; i < N; i++) fill(i, 8, 1, 0, 1);
        inv_valid = 1; inv_idx = 5'd7; @(negedge clk); inv_valid = 0;
        for (int i = 0; i < N; i++) look("R9", tag_of(i, 8), i, 0, 1, i != 7, frame_of(i, 8));

        // R10: fault clears only its index
        fill(7, 8, 1, 0, 1);
        fault_valid = 1; fault_idx = 5'd20; @(negedge clk); fault_valid = 0;
        for (int i = 0; i < N; i++) look("R10", tag_of(i, 8), i, 0, 0, i != 20, frame_of(i, 8));

        // R11: clear in the same cycle as a fill wins
        fill_valid = 1; fill_vpn = {tag_of(3, 9), 5'd3}; fill_frame = frame_of(3, 9);
        fill_user = 1; fill_write = 1; fill_global = 1;
        inv_valid = 1; inv_idx = 5'd3;
        @(negedge clk);
        fill_valid = 0; inv_valid = 0;
        look("R11", tag_of(3, 9), 3, 0, 0, 0, '0);
        fill_valid = 1; fill_vpn = {tag_of(4, 9), 5'd4}; fill_frame = frame_of(4, 9);
        fill_global = 0; fault_valid = 1; fault_idx = 5'd9;
        @(negedge clk);
        fill_valid = 0; fault_valid = 0;
        look("R11", tag_of(4, 9), 4, 0, 0, 1, frame_of(4, 9));
        fill_valid = 1; fill_vpn = {tag_of(5, 9), 5'd5}; fill_frame = frame_of(5, 9);
        fill_global = 0; root_load = 1;
        @(negedge clk);
        fill_valid = 0; root_load = 0;
        look("R11", tag_of(5, 9), 5, 0, 0, 0, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule